// File: doc/BRIEF.md
# Line Column Feeder

This block sits at the front of a two-dimensional rank or median filter. It keeps the last `WIN_H-1` scan lines of a pixel stream in on-chip line memories. For each accepted pixel it assembles the vertical column of `WIN_H` samples that share that pixel's horizontal position. The column is then handed to a downstream sorting core one sample per cycle, with the oldest line first and the live pixel last. This lets the core run at `WIN_H` times the pixel rate and take one column per pixel.

Line length is not a parameter. A horizontal sync strobe starts a new line, and the number of pixels stored since the previous strobe becomes that line's recorded length, up to `MAX_HRES`. A vertical sync strobe starts a new frame and marks every stored line as invalid. Each column sample carries a validity flag, so the core can tell real neighbours from missing rows at the top of a frame or past the end of a short line. The sync strobes come out delayed by the same one cycle as the first column sample.

The emitter is a two-state machine. In `ST_IDLE` no column is being sent. `ST_EMIT` sends samples with an index from 0 to `WIN_H-1`. Its transitions are:
- START: `ST_IDLE` to `ST_EMIT` when a pixel is accepted.
- STEP: `ST_EMIT` to `ST_EMIT` with the index incremented.
- CHAIN: `ST_EMIT` to `ST_EMIT` with the index back to 0, when a pixel is accepted while the last sample is showing.
- DRAIN: `ST_EMIT` to `ST_IDLE` after the last sample when no pixel arrives.

Top module: `line_column_feeder`

## Requirements
- R1: An accepted pixel makes `col_vld` high for exactly `WIN_H` consecutive enabled cycles, starting on the cycle after acceptance. Sample 0 comes from the oldest stored line, and sample `WIN_H-1` is the accepted pixel itself. `col_last` is high only on that final sample.
- R2: Sample k of a column (k < `WIN_H-1`) is the pixel at the same horizontal position in the line `WIN_H-1-k` lines before the current line.
- R3: A cycle with `hs_in` high starts a new line at position 0. A pixel accepted in that same cycle is position 0 of the new line, and the line just ended counts as a stored line for that pixel's column.
- R4: A stored-line sample has `col_ok` = 1 only if that line held more pixels than the current position. Otherwise `col_ok` = 0.
- R5: After a cycle with `vs_in` high, every line stored before it gives `col_ok` = 0, and that cycle starts a new line at position 0.
- R6: Within one line, at most `MAX_HRES` pixels are accepted. Further pixels produce no column and are not stored, and the recorded length of such a line is `MAX_HRES`.
- R7: Pixels are taken only when `pix_vld` is high. With `pix_vld` low, column emission continues and nothing is stored.
- R8: A pixel presented while a column is being sent, other than on the cycle showing its last sample, is discarded. It is not stored and does not advance the position.
- R9: With `ce` low, no register changes and all outputs hold, whatever `pix_vld`, `hs_in` or `vs_in` do. Only `rst` still acts.
- R10: A cycle with `rst` high, even with `ce` low, clears `col_vld`, `col_last`, `hs_out` and `vs_out` from the next cycle on. It invalidates all stored lines and restarts the position at 0.
- R11: `hs_out` and `vs_out` equal `hs_in` and `vs_in` as sampled at the previous enabled cycle.
- R12: The final sample of each column always has `col_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, overrides ce |
| ce | input | 1 | Clock enable; low freezes the block |
| pix_in | input | PIX_W | Incoming pixel magnitude |
| pix_vld | input | 1 | Pixel present this cycle |
| hs_in | input | 1 | Line-start strobe |
| vs_in | input | 1 | Frame-start strobe |
| col_data | output | PIX_W | Current column sample |
| col_ok | output | 1 | Sample comes from a real, filled line position |
| col_vld | output | 1 | A column sample is presented |
| col_last | output | 1 | Sample is the live pixel, ending the column |
| hs_out | output | 1 | Delayed line-start strobe |
| vs_out | output | 1 | Delayed frame-start strobe |

## Verification
A pixel accepted at one clock edge shows its oldest-line sample after that edge. The remaining samples follow at the next `WIN_H-1` enabled edges, and the sync strobes also appear one enabled edge after they are driven. The driver pushes `WIN_H` expected samples into a queue at the moment it presents each pixel. The monitor, sampling on the falling edge, pops one entry for each sample shown after an enabled edge. It checks instead that the outputs held wherever the previous edge had `ce` low. Sync-output checks are made on the falling edge right after the strobe's rising edge. Freeze and reset checks fall on the falling edges that follow the disabled or reset rising edges.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ser_state_t;
endpackage

// File: rtl/lcf_line_store.sv
module lcf_line_store #(
    parameter int PIX_W    = 8,
    parameter int WIN_H    = 3,
    parameter int MAX_HRES = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ce,
    input  logic                          wr,
    input  logic                          hs_in,
    input  logic                          vs_in,
    input  logic [PIX_W-1:0]              pix_in,
    output logic                          room,
    output logic [WIN_H-1:0][PIX_W-1:0]   col_data,
    output logic [WIN_H-1:0]              col_ok
);
    localparam int SLOTS = WIN_H - 1;
    localparam int XW    = $clog2(MAX_HRES + 1);
    localparam int AW    = $clog2(MAX_HRES);
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [PIX_W-1:0] mem [SLOTS][MAX_HRES];
    logic [XW-1:0]    slen [SLOTS];
    logic [SLOTS-1:0] sok;
    logic [SW-1:0]    wp, wp_eff;
    logic [XW-1:0]    xc, x_eff;
    logic [AW-1:0]    xa;
    logic             brk_h, brk_v;
    logic [SLOTS-1:0] ok_eff;
    logic [XW-1:0]    len_eff [SLOTS];

    function automatic logic [SW-1:0] slot_add(input logic [SW-1:0] a, input int k);
        int t;
        t = (int'(a) + k) % SLOTS;
        return SW'(t);
    endfunction

    // a strobe in this cycle already applies to a pixel taken in this cycle
    always_comb begin
        brk_v  = ce & vs_in;
        brk_h  = ce & hs_in & ~vs_in;
        wp_eff = brk_v ? '0 : (brk_h ? slot_add(wp, 1) : wp);
        x_eff  = (brk_v | brk_h) ? '0 : xc;
        room   = (x_eff < XW'(MAX_HRES));
        xa     = room ? AW'(x_eff) : '0;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign ok_eff[s]  = brk_v ? 1'b0 : ((brk_h && wp == SW'(s)) ? 1'b1 : sok[s]);
        assign len_eff[s] = (brk_h && wp == SW'(s)) ? xc : slen[s];
    end

    // row 0 is the slot being overwritten (oldest line), read before write
    for (genvar k = 0; k < SLOTS; k++) begin : g_row
        logic [SW-1:0] sl;
        assign sl          = slot_add(wp_eff, k);
        assign col_data[k] = mem[sl][xa];
        assign col_ok[k]   = ok_eff[sl] && (x_eff < len_eff[sl]);
    end
    assign col_data[WIN_H-1] = pix_in;
    assign col_ok[WIN_H-1]   = 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sok <= '0;
            wp  <= '0;
            xc  <= '0;
            for (int s = 0; s < SLOTS; s++) slen[s] <= '0;
        end else if (ce) begin
            if (vs_in) begin
                sok <= '0;
                wp  <= '0;
            end else if (hs_in) begin
                slen[wp] <= xc;
                sok[wp]  <= 1'b1;
                wp       <= slot_add(wp, 1);
            end
            xc <= x_eff + XW'(wr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr) mem[wp_eff][xa] <= pix_in;
    end

    p_xcap_r6: assert property (@(posedge clk) disable iff (rst)
        xc <= XW'(MAX_HRES));
    p_wr_room_r6: assert property (@(posedge clk) disable iff (rst)
        wr |-> room);
    p_vs_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && vs_in) |=> (sok == '0));
endmodule

// File: rtl/lcf_col_serial.sv
module lcf_col_serial
    import lcf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int WIN_H = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ce,
    input  logic                        start,
    input  logic [WIN_H-1:0][PIX_W-1:0] col_in,
    input  logic [WIN_H-1:0]            ok_in,
    output logic                        ready,
    output logic [PIX_W-1:0]            col_data,
    output logic                        col_ok,
    output logic                        col_vld,
    output logic                        col_last
);
    localparam int IW = $clog2(WIN_H);
    localparam logic [IW-1:0] LAST_I = IW'(WIN_H - 1);

    ser_state_t                  state;
    logic [IW-1:0]               idx, nidx;
    logic [WIN_H-1:0][PIX_W-1:0] cbuf;
    logic [WIN_H-1:0]            obuf;

    assign nidx  = idx + 1'b1;
    assign ready = (state == ST_IDLE) || (idx == LAST_I);

    // state register: START, STEP, CHAIN, DRAIN
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else if (ce) begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_EMIT;
                    idx   <= '0;
                end
                ST_EMIT: begin
                    if (idx != LAST_I)  idx   <= nidx;
                    else if (start)     idx   <= '0;
                    else                state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (start) begin
                cbuf <= col_in;
                obuf <= ok_in;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            col_vld  <= 1'b0;
            col_last <= 1'b0;
            col_ok   <= 1'b0;
        end else if (ce) begin
            if (start) begin
                col_data <= col_in[0];
                col_ok   <= ok_in[0];
                col_vld  <= 1'b1;
                col_last <= 1'b0;
            end else if (state == ST_EMIT && idx != LAST_I) begin
                col_data <= cbuf[nidx];
                col_ok   <= obuf[nidx];
                col_vld  <= 1'b1;
                col_last <= (nidx == LAST_I);
            end else begin
                col_vld  <= 1'b0;
                col_last <= 1'b0;
            end
        end
    end

    p_last_vld_r1: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_vld);
    p_run_r1: assert property (@(posedge clk) disable iff (rst)
        (ce && col_vld && !col_last) |=> col_vld);
    p_cur_ok_r12: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_ok);
    p_start_ready_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> ready);
    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(col_vld) && $stable(col_data) && $stable(col_last)));
endmodule

// File: rtl/line_column_feeder.sv
module line_column_feeder #(
    parameter int PIX_W    = 8,
    parameter int WIN_H    = 3,
    parameter int MAX_HRES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             pix_vld,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic [PIX_W-1:0] col_data,
    output logic             col_ok,
    output logic             col_vld,
    output logic             col_last,
    output logic             hs_out,
    output logic             vs_out
);
    logic                        ready, room, accept;
    logic [WIN_H-1:0][PIX_W-1:0] col_bus;
    logic [WIN_H-1:0]            ok_bus;

    assign accept = ce & ~rst & pix_vld & ready & room;

    lcf_line_store #(
        .PIX_W(PIX_W), .WIN_H(WIN_H), .MAX_HRES(MAX_HRES)
    ) u_store (
        .clk(clk), .rst(rst), .ce(ce), .wr(accept),
        .hs_in(hs_in), .vs_in(vs_in), .pix_in(pix_in),
        .room(room), .col_data(col_bus), .col_ok(ok_bus)
    );

    lcf_col_serial #(
        .PIX_W(PIX_W), .WIN_H(WIN_H)
    ) u_serial (
        .clk(clk), .rst(rst), .ce(ce), .start(accept),
        .col_in(col_bus), .ok_in(ok_bus), .ready(ready),
        .col_data(col_data), .col_ok(col_ok),
        .col_vld(col_vld), .col_last(col_last)
    );

    // one-cycle delay, matching the first column sample
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_out <= 1'b0;
            vs_out <= 1'b0;
        end else if (ce) begin
            hs_out <= hs_in;
            vs_out <= vs_in;
        end
    end

    p_sync_delay_r11: assert property (@(posedge clk) disable iff (rst)
        ce |=> ((hs_out == $past(hs_in)) && (vs_out == $past(vs_in))));
endmodule

// File: tb/line_column_feeder_bench.sv
`timescale 1ns/1ps
module line_column_feeder_bench;
    localparam int WH   = 3;
    localparam int MAXH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b1;
    logic [7:0] pix = 8'h00;
    logic       pix_vld = 1'b0;
    logic       hs = 1'b0;
    logic       vs = 1'b0;
    logic [7:0] col_data;
    logic       col_ok, col_vld, col_last, hs_out, vs_out;

    always #4 clk = ~clk;

    line_column_feeder #(.PIX_W(8), .WIN_H(WH), .MAX_HRES(MAXH)) u_line_column_feeder (
        .clk(clk), .rst(rst), .ce(ce), .pix_in(pix), .pix_vld(pix_vld),
        .hs_in(hs), .vs_in(vs), .col_data(col_data), .col_ok(col_ok),
        .col_vld(col_vld), .col_last(col_last), .hs_out(hs_out), .vs_out(vs_out)
    );

    typedef struct {
        logic [7:0] d;
        logic       ok;
        logic       last;
        string      req;
    } exp_t;

    exp_t q[$];
    int   nchk = 0;
    int   nbad = 0;
    bit   done = 1'b0;

    // reference model of the stored lines
    logic [7:0] mpix [0:63][0:MAXH-1];
    int         mlen [0:63];
    int         line = 0;
    int         mx = 0;

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        nchk++;
        if (!cond) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic m_hs();
        mlen[line] = mx;
        line++;
        mx = 0;
    endtask

    task automatic m_vs();
        line = 0;
        mx = 0;
    endtask

    task automatic m_push(input logic [7:0] v, input string req);
        exp_t e;
        if (mx < MAXH) begin
            for (int k = 0; k < WH - 1; k++) begin
                int ln;
                ln = line - (WH - 1) + k;
                e.ok   = (ln >= 0) && (mx < mlen[ln]);
                e.d    = e.ok ? mpix[ln][mx] : 8'h00;
                e.last = 1'b0;
                e.req  = req;
                q.push_back(e);
            end
            e.d = v; e.ok = 1'b1; e.last = 1'b1; e.req = req;
            q.push_back(e);
            mpix[line][mx] = v;
            mx++;
        end
    endtask

    function automatic logic [7:0] pv(input int l, input int x);
        return 8'((l * 16 + x + 1) % 256);
    endfunction

    task automatic send_px(input logic [7:0] v, input string req);
        @(negedge clk);
        pix = v; pix_vld = 1'b1;
        m_push(v, req);
        @(negedge clk);
        pix_vld = 1'b0;
        repeat (WH - 2) @(negedge clk);
    endtask

    task automatic send_line(input int l, input int n, input string req);
        for (int i = 0; i < n; i++) send_px(pv(l, i), req);
    endtask

    task automatic do_hs();
        @(negedge clk);
        hs = 1'b1;
        m_hs();
        @(negedge clk);
        hs = 1'b0;
        chk(hs_out === 1'b1, "R11 hs_out", int'(hs_out), 1);
    endtask

    task automatic do_vs();
        @(negedge clk);
        vs = 1'b1;
        m_vs();
        @(negedge clk);
        vs = 1'b0;
        chk(vs_out === 1'b1, "R11 vs_out", int'(vs_out), 1);
    endtask

    // monitor: one queue entry per sample shown after an enabled edge
    logic       ce_q = 1'b0;
    logic [7:0] prev_d = 8'h00;
    always @(posedge clk) ce_q <= ce;

    always @(negedge clk) begin
        if (!done && col_vld === 1'b1) begin
            if (ce_q) begin
                nchk++;
                if (q.size() == 0) begin
                    nbad++;
                    $display("FAIL R1: unexpected sample actual=%0h expected=none", col_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (col_ok !== e.ok || col_last !== e.last || (e.ok && col_data !== e.d)) begin
                        nbad++;
                        $display("FAIL %s: actual d=%0h ok=%0b last=%0b expected d=%0h ok=%0b last=%0b",
                                 e.req, col_data, col_ok, col_last, e.d, e.ok, e.last);
                    end
                end
                prev_d = col_data;
            end else begin
                nchk++;
                if (col_data !== prev_d) begin
                    nbad++;
                    $display("FAIL R9: held data actual=%0h expected=%0h", col_data, prev_d);
                end
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(col_vld === 1'b0, "R10 reset vld", int'(col_vld), 0);
        chk(hs_out === 1'b0 && vs_out === 1'b0, "R10 reset sync", int'({hs_out, vs_out}), 0);
        rst = 1'b0;

        do_vs();                       // R5 frame start
        send_line(0, 4, "R1");         // no stored rows yet
        do_hs();
        send_line(1, 4, "R2");
        do_hs();
        send_line(2, 6, "R4");         // positions 4,5 past shorter lines
        do_hs();
        send_line(3, 10, "R6");        // two pixels past MAX_HRES dropped
        do_hs();
        send_line(4, 8, "R6");         // line 3 recorded at MAX_HRES

        // R3: strobe and first pixel in the same cycle
        @(negedge clk);
        hs = 1'b1; pix = pv(5, 0); pix_vld = 1'b1;
        m_hs();
        m_push(pv(5, 0), "R3");
        @(negedge clk);
        hs = 1'b0; pix_vld = 1'b0;
        chk(hs_out === 1'b1, "R11 hs_out", int'(hs_out), 1);
        repeat (WH - 2) @(negedge clk);
        send_px(pv(5, 1), "R3");
        send_px(pv(5, 2), "R3");

        // R8: second pixel while busy is discarded
        @(negedge clk);
        pix = pv(5, 3); pix_vld = 1'b1;
        m_push(pv(5, 3), "R8");
        @(negedge clk);
        pix = 8'hBB;
        @(negedge clk);
        pix_vld = 1'b0;
        @(negedge clk);
        send_px(pv(5, 4), "R8");
        do_hs();

        send_line(6, 2, "R2");
        // R9: freeze during emission with garbage on all inputs
        @(negedge clk);
        pix = pv(6, 2); pix_vld = 1'b1;
        m_push(pv(6, 2), "R9");
        @(negedge clk);
        ce = 1'b0; pix = 8'hEE; hs = 1'b1; vs = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(hs_out === 1'b0 && vs_out === 1'b0, "R9 sync held", int'({hs_out, vs_out}), 0);
        end
        ce = 1'b1; pix_vld = 1'b0; hs = 1'b0; vs = 1'b0;
        repeat (WH - 1) @(negedge clk);
        // R7: long gaps with pix_vld low, nothing stored meanwhile
        for (int i = 3; i < 6; i++) begin
            send_px(pv(6, i), "R7");
            repeat (4) @(negedge clk);
        end

        do_vs();
        send_line(8, 3, "R5");         // older lines must read invalid
        do_hs();
        send_line(9, 3, "R5");

        // R10: reset mid-column, with ce low
        @(negedge clk);
        pix = pv(10, 0); pix_vld = 1'b1;
        m_push(pv(10, 0), "R10");
        @(negedge clk);
        pix_vld = 1'b0; rst = 1'b1; ce = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; ce = 1'b1;
        chk(col_vld === 1'b0, "R10 vld cleared", int'(col_vld), 0);
        chk(hs_out === 1'b0 && vs_out === 1'b0, "R10 sync cleared", int'({hs_out, vs_out}), 0);
        q.delete();
        m_vs();
        send_line(11, 2, "R10");
        do_hs();
        send_line(12, 2, "R10");

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R1 all samples seen", q.size(), 0);
        finish_up();
    end
endmodule